// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer Array

This block hangs eight timer channels off a shared 16-bit free-running count. That count, and a one-cycle strobe marking each prescaled step, come from a counter outside the block. Each channel owns one 16-bit register whose job depends on a per-channel mode bit. In capture mode the register records the count when a chosen edge arrives on the channel's input pin. In compare mode the register holds a target value, and when the count reaches it the channel drives its output pin in a programmed way.

Every capture or compare event raises that channel's flag. Software clears a flag by writing a 1 to its bit. A per-channel enable decides whether a raised flag reaches the shared interrupt line. Input pins are asynchronous and pass through a two-flop synchroniser before edge detection. Software programs the block through a byte-wide register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `capcmp_array`

## Requirements
- R1: After reset, all channel registers, the mode, edge, action, enable and flag registers, and `pinOut` are 0. `pinOutEn` and `irq` are low.
- R2: Channel n's register is reached byte-wise: its upper byte at address 2n and its lower byte at address 2n+1. A byte write changes only that byte, and reads return the stored value.
- R3: The mode register sits at address 16. Bit n = 1 puts channel n in compare mode and bit n = 0 puts it in capture mode.
- R4: Edge selection uses 2 bits per channel: channels 0-3 at address 17 and channels 4-7 at address 18, with channel n in bits [2(n mod 4)+1 : 2(n mod 4)]. The codes are 00 none, 01 rising, 10 falling, 11 both. A selected edge on a capture-mode pin loads the count into the channel register and sets its flag. Register and flag change on the third rising clock edge after the pin changes, and the value loaded is the count present during the cycle before that edge.
- R5: A compare-mode channel fires only in a cycle where `cntTick` is 1 and `cntVal` equals its register. Its flag is set at the next clock edge, and an equal count without `cntTick` does nothing.
- R6: Output actions use the same 2-bit layout at addresses 19 (channels 0-3) and 20 (channels 4-7). The codes are 00 disconnected, 01 toggle, 10 drive low, 11 drive high. On a compare fire the pin changes on the same edge as the flag. With code 00 the pin holds its value. `pinOutEn[n]` is 1 exactly when channel n is in compare mode with a non-zero action.
- R7: The interrupt enable register sits at address 21. `irq` is high whenever some channel has both its flag and its enable bit set.
- R8: The flag register sits at address 22 and reads back the eight flags. Writing 1 to a bit clears that flag, and writing 0 leaves it alone. An event in the same cycle as a clear of that flag leaves the flag set.
- R9: Edges on a compare-mode channel do not capture. Count matches on a capture-mode channel neither set the flag nor move the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntVal | input | 16 | Shared free-running count |
| cntTick | input | 1 | High in each cycle where `cntVal` holds a newly advanced value |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| pinIn | input | 8 | Asynchronous channel input pins |
| pinOut | output | 8 | Channel output pin levels |
| pinOutEn | output | 8 | Output drive enable per channel |
| irq | output | 1 | Combined, enabled channel interrupt |

## Verification
The two functions that can meet in one cycle are a hardware event setting a flag and a software write clearing the same flag. The bench provokes this with a directed case: it presents a matching count with `cntTick` in the very cycle the write-1-to-clear reaches the flag register, and then expects the flag still set. A random phase then mixes count matches, random clear masks and random output actions on all channels, comparing flags, pins and `irq` every cycle against a bench model. Both orders of clear and event occur there often.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  parameter int NUM_CH = 8;
  parameter int CNT_W  = 16;
  parameter int ADDR_W = 5;

  localparam int CFG_BYTES = (2 * NUM_CH) / 8;
  localparam int A_MODE_I  = 2 * NUM_CH;
  localparam int A_EDGE_I  = A_MODE_I + 1;
  localparam int A_ACT_I   = A_EDGE_I + CFG_BYTES;
  localparam int A_IE_I    = A_ACT_I + CFG_BYTES;
  localparam int A_FLG_I   = A_IE_I + 1;

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(A_MODE_I);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(A_IE_I);
  localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(A_FLG_I);

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrHi;
    logic [NUM_CH-1:0] wrLo;
    logic [7:0]        wrByte;
  } chanStrobe_t;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [7:0]                        busWdata,
  output logic [7:0]                        busRdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      chanReg,
  input  logic [NUM_CH-1:0]                 evtVec,
  output chanStrobe_t                       stb,
  output logic [NUM_CH-1:0]                 modeVec,
  output logic [2*NUM_CH-1:0]               edgeFlat,
  output logic [2*NUM_CH-1:0]               actFlat,
  output logic [NUM_CH-1:0]                 ieVec,
  output logic [NUM_CH-1:0]                 flagVec,
  output logic                              irq
);
  logic [NUM_CH-1:0] clrMask;

  // strobes toward the datapath
  always_comb begin
    stb.wrByte = busWdata;
    for (int i = 0; i < NUM_CH; i++) begin
      stb.wrHi[i] = busWr && (busAddr == ADDR_W'(2 * i));
      stb.wrLo[i] = busWr && (busAddr == ADDR_W'(2 * i + 1));
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeVec  <= '0;
      edgeFlat <= '0;
      actFlat  <= '0;
      ieVec    <= '0;
    end else if (busWr) begin
      if (busAddr == A_MODE) modeVec <= busWdata[NUM_CH-1:0];
      if (busAddr == A_IE)   ieVec   <= busWdata[NUM_CH-1:0];
      for (int j = 0; j < CFG_BYTES; j++) begin
        if (busAddr == ADDR_W'(A_EDGE_I + j)) edgeFlat[8*j +: 8] <= busWdata;
        if (busAddr == ADDR_W'(A_ACT_I + j))  actFlat[8*j +: 8]  <= busWdata;
      end
    end
  end

  // flags: hardware set has priority over write-one-to-clear
  assign clrMask = (busWr && busAddr == A_FLG) ? busWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flagVec <= '0;
    else        flagVec <= (flagVec & ~clrMask) | evtVec;
  end

  assign irq = |(flagVec & ieVec);

  // read mux
  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(2 * i))     busRdata = chanReg[i][CNT_W-1:8];
      if (busAddr == ADDR_W'(2 * i + 1)) busRdata = chanReg[i][7:0];
    end
    for (int j = 0; j < CFG_BYTES; j++) begin
      if (busAddr == ADDR_W'(A_EDGE_I + j)) busRdata = edgeFlat[8*j +: 8];
      if (busAddr == ADDR_W'(A_ACT_I + j))  busRdata = actFlat[8*j +: 8];
    end
    if (busAddr == A_MODE) busRdata = modeVec;
    if (busAddr == A_IE)   busRdata = ieVec;
    if (busAddr == A_FLG)  busRdata = flagVec;
  end
endmodule

// File: rtl/capcmp_dp.sv
module capcmp_dp
  import capcmp_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CNT_W-1:0]                  cntVal,
  input  logic                              cntTick,
  input  logic [NUM_CH-1:0]                 pinIn,
  input  chanStrobe_t                       stb,
  input  logic [NUM_CH-1:0]                 modeVec,
  input  logic [2*NUM_CH-1:0]               edgeFlat,
  input  logic [2*NUM_CH-1:0]               actFlat,
  output logic [NUM_CH-1:0][CNT_W-1:0]      chanReg,
  output logic [NUM_CH-1:0]                 evtVec,
  output logic [NUM_CH-1:0]                 pinOut,
  output logic [NUM_CH-1:0]                 pinOutEn
);
  logic [NUM_CH-1:0] syncA, syncB, syncC;

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic     rise, fall, capHit, cmpHit;
    edgeSel_e edgeSel;
    act_e     act;

    assign edgeSel = edgeSel_e'(edgeFlat[2*i +: 2]);
    assign act     = act_e'(actFlat[2*i +: 2]);
    assign rise    = syncB[i] & ~syncC[i];
    assign fall    = ~syncB[i] & syncC[i];

    always_comb begin
      unique case (edgeSel)
        EDGE_RISE: capHit = rise;
        EDGE_FALL: capHit = fall;
        EDGE_BOTH: capHit = rise | fall;
        default:   capHit = 1'b0;
      endcase
      capHit = capHit & ~modeVec[i];
    end

    assign cmpHit      = modeVec[i] && cntTick && (cntVal == chanReg[i]);
    assign evtVec[i]   = capHit | cmpHit;
    assign pinOutEn[i] = modeVec[i] && (act != ACT_NONE);

    // channel register: capture overrides a bus write in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chanReg[i] <= '0;
      end else if (capHit) begin
        chanReg[i] <= cntVal;
      end else begin
        if (stb.wrHi[i]) chanReg[i][CNT_W-1:8] <= stb.wrByte;
        if (stb.wrLo[i]) chanReg[i][7:0]       <= stb.wrByte;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pinOut[i] <= 1'b0;
      end else if (cmpHit) begin
        unique case (act)
          ACT_TOGGLE: pinOut[i] <= ~pinOut[i];
          ACT_CLEAR:  pinOut[i] <= 1'b0;
          ACT_SET:    pinOut[i] <= 1'b1;
          default:    pinOut[i] <= pinOut[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/capcmp_array.sv
module capcmp_array
  import capcmp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cntVal,
  input  logic                 cntTick,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  input  logic [NUM_CH-1:0]    pinIn,
  output logic [NUM_CH-1:0]    pinOut,
  output logic [NUM_CH-1:0]    pinOutEn,
  output logic                 irq
);
  chanStrobe_t                   stb;
  logic [NUM_CH-1:0][CNT_W-1:0]  chanReg;
  logic [NUM_CH-1:0]             evtVec, modeVec, ieVec, flagVec;
  logic [2*NUM_CH-1:0]           edgeFlat, actFlat;

  capcmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .chanReg(chanReg),
    .evtVec(evtVec), .stb(stb), .modeVec(modeVec), .edgeFlat(edgeFlat),
    .actFlat(actFlat), .ieVec(ieVec), .flagVec(flagVec), .irq(irq)
  );

  capcmp_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cntVal(cntVal), .cntTick(cntTick),
    .pinIn(pinIn), .stb(stb), .modeVec(modeVec), .edgeFlat(edgeFlat),
    .actFlat(actFlat), .chanReg(chanReg), .evtVec(evtVec),
    .pinOut(pinOut), .pinOutEn(pinOutEn)
  );
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker
  import capcmp_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [7:0]          busWdata,
  input logic [NUM_CH-1:0]   modeVec,
  input logic [NUM_CH-1:0]   ieVec,
  input logic [NUM_CH-1:0]   flagVec,
  input logic [NUM_CH-1:0]   evtVec,
  input logic [2*NUM_CH-1:0] actFlat,
  input logic [NUM_CH-1:0]   pinOut,
  input logic                irq
);
  a_r7_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ieVec == '0) |-> !irq);
  a_r7_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (flagVec == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      evtVec[i] |=> flagVec[i]);
    a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (busWr && busAddr == A_FLG && busWdata[i] && !evtVec[i]) |=> !flagVec[i]);
    a_r9_capture_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !modeVec[i] |=> $stable(pinOut[i]));
    a_r6_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (evtVec[i] && modeVec[i] && actFlat[2*i +: 2] == 2'b11) |=> pinOut[i]);
    a_r6_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (evtVec[i] && modeVec[i] && actFlat[2*i +: 2] == 2'b10) |=> !pinOut[i]);
  end
endmodule

bind capcmp_array capcmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .modeVec(modeVec), .ieVec(ieVec), .flagVec(flagVec),
  .evtVec(evtVec), .actFlat(actFlat), .pinOut(pinOut), .irq(irq)
);

// File: tb/capcmp_array_test.sv
module capcmp_array_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cntVal = '0;
  logic        cntTick = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut, pinOutEn;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  capcmp_array uut (
    .clk(clk), .rst_n(rst_n), .cntVal(cntVal), .cntTick(cntTick),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tickAt(input logic [15:0] v);
    @(negedge clk);
    cntVal = v; cntTick = 1'b1;
    @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic nextPin(input logic cur, input logic [1:0] act, input logic hit);
    if (!hit) return cur;
    case (act)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] mReg [8];
    logic [7:0]  mPin, mFlag, mActLo, mActHi;
    logic [15:0] act16;
    void'($urandom(32'd2024));

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 pinOut", pinOut, 0);
    chk("R1 pinOutEn", pinOutEn, 0);
    chk("R1 irq", irq, 0);
    rd(5'd22, rv); chk("R1 flags", rv, 0);
    rd(5'd0, rv);  chk("R1 chan0 high", rv, 0);
    rd(5'd16, rv); chk("R1 mode", rv, 0);

    // R2 byte access
    wr(5'd6, 8'hAB); wr(5'd7, 8'hCD);
    rd(5'd6, rv); chk("R2 chan3 high", rv, 8'hAB);
    rd(5'd7, rv); chk("R2 chan3 low", rv, 8'hCD);
    rd(5'd4, rv); chk("R2 chan2 untouched", rv, 8'h00);
    wr(5'd7, 8'h11);
    rd(5'd6, rv); chk("R2 high kept on low write", rv, 8'hAB);

    // R4 rising capture on channel 1 with latency
    wr(5'd17, 8'h04);
    cntVal = 16'h1234;
    @(negedge clk); pinIn[1] = 1'b1; busAddr = 5'd22;
    @(posedge clk); @(posedge clk); @(negedge clk);
    #1 chk("R4 no flag before third edge", busRdata[1], 0);
    @(posedge clk); @(negedge clk);
    #1 chk("R4 flag on third edge", busRdata[1], 1);
    rd(5'd2, rv); chk("R4 captured high", rv, 8'h12);
    rd(5'd3, rv); chk("R4 captured low", rv, 8'h34);
    wr(5'd22, 8'h02);
    rd(5'd22, rv); chk("R8 write one clears", rv, 0);

    // R4 falling edge ignored in rising mode
    cntVal = 16'h5555;
    @(negedge clk) pinIn[1] = 1'b0;
    waitCycles(5);
    rd(5'd22, rv); chk("R4 falling ignored", rv, 0);
    rd(5'd3, rv);  chk("R4 register kept", rv, 8'h34);

    // R4 falling mode
    wr(5'd17, 8'h08);
    @(negedge clk) pinIn[1] = 1'b1;
    waitCycles(5);
    rd(5'd22, rv); chk("R4 rise ignored in falling mode", rv, 0);
    cntVal = 16'h0777;
    @(negedge clk) pinIn[1] = 1'b0;
    waitCycles(5);
    rd(5'd22, rv); chk("R4 falling captured flag", rv, 8'h02);
    rd(5'd2, rv);  chk("R4 falling captured value", rv, 8'h07);
    wr(5'd22, 8'h02);

    // R4 both edges
    wr(5'd17, 8'h0C);
    cntVal = 16'h0100;
    @(negedge clk) pinIn[1] = 1'b1;
    waitCycles(5);
    rd(5'd2, rv); chk("R4 both rise value", rv, 8'h01);
    wr(5'd22, 8'h02);
    cntVal = 16'h0200;
    @(negedge clk) pinIn[1] = 1'b0;
    waitCycles(5);
    rd(5'd2, rv); chk("R4 both fall value", rv, 8'h02);
    rd(5'd22, rv); chk("R4 both fall flag", rv, 8'h02);
    wr(5'd22, 8'h02);

    // R4 disabled edge code
    wr(5'd17, 8'h00);
    cntVal = 16'h0900;
    @(negedge clk) pinIn[1] = 1'b1;
    waitCycles(5);
    rd(5'd22, rv); chk("R4 disabled edge no flag", rv, 0);
    rd(5'd2, rv);  chk("R4 disabled edge no capture", rv, 8'h02);

    // R9 capture-mode channel ignores count match (reg = 0x0200)
    tickAt(16'h0200);
    rd(5'd22, rv); chk("R9 no compare in capture mode", rv, 0);
    chk("R9 pin unchanged", pinOut, 0);

    // R3 / R5 / R6 compare on channel 2
    wr(5'd16, 8'h04);
    rd(5'd16, rv); chk("R3 mode readback", rv, 8'h04);
    wr(5'd4, 8'h00); wr(5'd5, 8'h10);
    wr(5'd19, 8'h30);
    chk("R6 output enable", pinOutEn, 8'h04);
    @(negedge clk) cntVal = 16'h0010;
    waitCycles(2);
    rd(5'd22, rv); chk("R5 no fire without tick", rv, 0);
    tickAt(16'h0010);
    chk("R6 set action", pinOut[2], 1);
    rd(5'd22, rv); chk("R5 compare flag", rv, 8'h04);
    wr(5'd22, 8'h04);

    // R9 edge on compare-mode channel does not capture
    wr(5'd17, 8'h10);
    cntVal = 16'h4444;
    @(negedge clk) pinIn[2] = 1'b1;
    waitCycles(5);
    rd(5'd22, rv); chk("R9 no capture in compare mode", rv, 0);
    rd(5'd5, rv);  chk("R9 compare register kept", rv, 8'h10);

    wr(5'd19, 8'h20); tickAt(16'h0010);
    chk("R6 clear action", pinOut[2], 0);
    wr(5'd19, 8'h10); tickAt(16'h0010);
    chk("R6 toggle to one", pinOut[2], 1);
    tickAt(16'h0010);
    chk("R6 toggle to zero", pinOut[2], 0);
    wr(5'd19, 8'h00);
    chk("R6 disconnected no enable", pinOutEn, 0);
    tickAt(16'h0010);
    chk("R6 disconnected pin holds", pinOut[2], 0);

    // R7 interrupt gating (flag 2 set by last tick)
    chk("R7 irq off with enable clear", irq, 0);
    wr(5'd21, 8'h04);
    chk("R7 irq on", irq, 1);
    wr(5'd21, 8'h02);
    chk("R7 other enable no irq", irq, 0);
    wr(5'd21, 8'h04);
    wr(5'd22, 8'h04);
    chk("R7 irq off after clear", irq, 0);

    // R8 event and clear in the same cycle: event wins
    @(negedge clk);
    cntVal = 16'h0010; cntTick = 1'b1;
    busWr = 1'b1; busAddr = 5'd22; busWdata = 8'h04;
    @(negedge clk);
    cntTick = 1'b0; busWr = 1'b0;
    rd(5'd22, rv); chk("R8 set wins over clear", rv, 8'h04);
    wr(5'd22, 8'h00);
    rd(5'd22, rv); chk("R8 write zero keeps flag", rv, 8'h04);

    // Random phase: all channels compare, random actions, clears and ticks
    wr(5'd16, 8'hFF);
    wr(5'd21, 8'hFF);
    for (int c = 0; c < 8; c++) begin
      mReg[c] = 16'($urandom % 4);
      wr(5'(2*c), mReg[c][15:8]);
      wr(5'(2*c+1), mReg[c][7:0]);
    end
    mActLo = 8'($urandom); mActHi = 8'($urandom);
    wr(5'd19, mActLo); wr(5'd20, mActHi);
    wr(5'd22, 8'hFF);
    mFlag = 8'h00;
    @(negedge clk);
    mPin = pinOut;
    busAddr = 5'd22;
    act16 = {mActHi, mActLo};
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] hit, clr;
      #1;
      chk("R6 random pins", pinOut, mPin);
      chk("R8 random flags", busRdata, mFlag);
      chk("R7 random irq", irq, |mFlag);
      chk("R6 random enable", pinOutEn, {act16[15:14] != 0, act16[13:12] != 0,
          act16[11:10] != 0, act16[9:8] != 0, act16[7:6] != 0, act16[5:4] != 0,
          act16[3:2] != 0, act16[1:0] != 0});
      cntVal = 16'($urandom % 4);
      cntTick = 1'($urandom % 2);
      clr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      busWr = (clr != 0);
      busWdata = clr;
      for (int c = 0; c < 8; c++) begin
        hit[c] = cntTick && (cntVal == mReg[c]);
        mPin[c] = nextPin(mPin[c], act16[2*c +: 2], hit[c]);
      end
      mFlag = (mFlag & ~clr) | hit;
      @(negedge clk);
    end
    busWr = 1'b0; cntTick = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule